// File: doc/BRIEF.md
# Numbered Hardware Queue Bank

This block answers queue reads issued by an execute stage. Each request names a queue by a 4-bit number and asks for one of two operations. A pop returns the oldest entry of that queue and removes it. A peek returns the same entry and leaves the queue as it was. The number may come from a register operand or from an immediate field; the block only sees the resolved value. One shared request port serves every queue number, and the answer comes back on a registered response port one clock later.

Only number 15 is populated. It is a trace buffer. Every instruction the core commits presents its instruction pointer on the trace input, and that value is appended to queue 15 without any software action. When the buffer is full, the oldest record is discarded so that the most recent history survives. Every other number is treated as undefined.

Top module: `qbank_top`

## Requirements
- R1: `req_qid` selects the queue, and number 15 is the trace queue. A request to it returns the oldest stored instruction pointer on `rsp_data` with `rsp_empty` = 0.
- R2: A peek (`req_op` = 0) does not change the queue. Repeated peeks return the same head, and a later pop still returns that head.
- R3: A pop (`req_op` = 1) returns the head and removes it. Successive pops return entries in the order they were pushed.
- R4: A request to any number other than 15 returns zero with `rsp_empty` = 1. This holds for both pop and peek, and the trace queue is left unchanged.
- R5: A pop or peek of the trace queue while it holds nothing returns zero with `rsp_empty` = 1, and removes nothing.
- R6: `rsp_vld` is high in exactly the cycles that follow a cycle in which `req_vld` was high.
- R7: The trace queue holds at most 16 entries. A push into a full queue with no pop in the same cycle discards the oldest entry.
- R8: A push and a pop of the trace queue in the same cycle both take effect when the queue is non-empty. The pop returns the previous head, and the entry count is unchanged, including when the queue is full.
- R9: A request sees the queue as it was before the same-cycle push. A peek issued in the cycle that pushes into an empty queue reports empty.
- R10: After reset `rsp_vld` is low and the trace queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trc_vld | input | 1 | A committed instruction is presented this cycle |
| trc_ip | input | 64 | Instruction pointer of that committed instruction |
| req_vld | input | 1 | A queue request is issued this cycle |
| req_op | input | 1 | 0 = peek, 1 = pop |
| req_qid | input | 4 | Queue number |
| rsp_vld | output | 1 | Response to the previous cycle's request |
| rsp_data | output | 64 | Head value, or zero when nothing is available |
| rsp_empty | output | 1 | 1 when the queue number was undefined or the queue was empty |

## Verification
The bench builds the block with its default parameters: 64-bit entries, a 16-entry trace queue, 4-bit queue numbers and trace number 15. With a depth of only 16, a twenty-push burst is enough to overfill the buffer and exercise the discard path. The bench can then push and pop on a full buffer and drain it completely to confirm the count. The 4-bit number space lets the bench probe undefined queues at both ends (0 and 14) as well as in the middle.

// File: rtl/qbank_pkg.sv
`timescale 1ns/1ps
package qbank_pkg;
  typedef enum logic {
    QOP_PEEK = 1'b0,
    QOP_POP  = 1'b1
  } qop_e;
endpackage

// File: rtl/qbank_rst_sync.sv
`timescale 1ns/1ps
// Asserts asynchronously, releases after two clock edges.
module qbank_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_o = sh_q[1];
endmodule

// File: rtl/qbank_decode.sv
`timescale 1ns/1ps
// Maps a request onto the populated queue.
module qbank_decode
  import qbank_pkg::*;
#(
  parameter int unsigned QID_W     = 4,
  parameter int unsigned TRACE_QID = 15
) (
  input  logic             req_vld,
  input  qop_e             req_op,
  input  logic [QID_W-1:0] req_qid,
  output logic             trc_hit,
  output logic             trc_pop
);
  localparam logic [QID_W-1:0] TRC_ID = QID_W'(TRACE_QID);

  always_comb begin
    trc_hit = req_vld && (req_qid == TRC_ID);
    trc_pop = trc_hit && (req_op == QOP_POP);
  end
endmodule

// File: rtl/qbank_trace_ring.sv
`timescale 1ns/1ps
// Circular buffer that overwrites its oldest entry when full.
module qbank_trace_ring #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full, take, drop, adv;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full  = (cnt_q == CNT_FULL);
    empty = (cnt_q == '0);
    take  = pop && !empty;
    drop  = push && full && !take;
    adv   = take || drop;
    rd_d  = adv  ? ptr_inc(rd_q) : rd_q;
    wr_d  = push ? ptr_inc(wr_q) : wr_q;
    if (push && !adv)      cnt_d = cnt_q + 1'b1;
    else if (!push && adv) cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (adv)          rd_q  <= rd_d;
      if (push)         wr_q  <= wr_d;
      if (push || adv)  cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; slots are read only after being written.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (wr_q == PTR_W'(i))) mem[i] <= push_data;
    end
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/qbank_resp.sv
`timescale 1ns/1ps
// Registered response: zero plus empty flag when nothing is available.
module qbank_resp #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              trc_hit,
  input  logic              trc_empty,
  input  logic [DATA_W-1:0] trc_head,
  output logic              rsp_vld,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_empty
);
  logic              vld_q;
  logic [DATA_W-1:0] data_q, data_d;
  logic              emp_q, emp_d;
  logic              avail;

  always_comb begin
    avail  = trc_hit && !trc_empty;
    data_d = avail ? trc_head : '0;
    emp_d  = !avail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      emp_q  <= 1'b1;
    end else begin
      vld_q <= req_vld;
      if (req_vld) begin
        data_q <= data_d;
        emp_q  <= emp_d;
      end
    end
  end

  assign rsp_vld   = vld_q;
  assign rsp_data  = data_q;
  assign rsp_empty = emp_q;
endmodule

// File: rtl/qbank_top.sv
`timescale 1ns/1ps
module qbank_top
  import qbank_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned QID_W     = 4,
  parameter int unsigned TRACE_QID = 15,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trc_vld,
  input  logic [DATA_W-1:0] trc_ip,
  input  logic              req_vld,
  input  logic              req_op,
  input  logic [QID_W-1:0]  req_qid,
  output logic              rsp_vld,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_empty
);
  logic              rst_sync_n;
  logic              trc_hit, trc_pop, trc_empty;
  logic [DATA_W-1:0] trc_head;
  logic [CNT_W-1:0]  trc_cnt;

  qbank_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  qbank_decode #(.QID_W(QID_W), .TRACE_QID(TRACE_QID)) u_dec (
    .req_vld (req_vld),
    .req_op  (qop_e'(req_op)),
    .req_qid (req_qid),
    .trc_hit (trc_hit),
    .trc_pop (trc_pop)
  );

  qbank_trace_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (trc_vld),
    .push_data (trc_ip),
    .pop       (trc_pop),
    .head      (trc_head),
    .empty     (trc_empty),
    .count     (trc_cnt)
  );

  qbank_resp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_vld   (req_vld),
    .trc_hit   (trc_hit),
    .trc_empty (trc_empty),
    .trc_head  (trc_head),
    .rsp_vld   (rsp_vld),
    .rsp_data  (rsp_data),
    .rsp_empty (rsp_empty)
  );
endmodule

// File: rtl/qbank_checker.sv
`timescale 1ns/1ps
module qbank_checker #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned QID_W     = 4,
  parameter int unsigned TRACE_QID = 15,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trc_vld,
  input logic              req_vld,
  input logic              req_op,
  input logic [QID_W-1:0]  req_qid,
  input logic              rsp_vld,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_empty,
  input logic [CNT_W-1:0]  trc_cnt
);
  localparam logic [QID_W-1:0] TRC_ID = QID_W'(TRACE_QID);

  a_r6_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  a_r4_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_qid != TRC_ID) |=> (rsp_empty && rsp_data == '0));
  a_r5_empty_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_empty) |-> (rsp_data == '0));
  a_r2_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_op && !trc_vld) |=> $stable(trc_cnt));
  a_r3_pop_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_op && req_qid == TRC_ID && !trc_vld && trc_cnt != '0)
      |=> (trc_cnt == $past(trc_cnt) - 1'b1));
  a_r8_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_op && req_qid == TRC_ID && trc_vld && trc_cnt != '0)
      |=> $stable(trc_cnt));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    trc_cnt <= CNT_W'(DEPTH));
endmodule

bind qbank_top qbank_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .QID_W(QID_W), .TRACE_QID(TRACE_QID)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .trc_vld   (trc_vld),
  .req_vld   (req_vld),
  .req_op    (req_op),
  .req_qid   (req_qid),
  .rsp_vld   (rsp_vld),
  .rsp_data  (rsp_data),
  .rsp_empty (rsp_empty),
  .trc_cnt   (trc_cnt)
);

// File: tb/qbank_top_tb_top.sv
`timescale 1ns/1ps
module qbank_top_tb_top;
  localparam int DW = 64;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trc_vld;
  logic [DW-1:0] trc_ip;
  logic          req_vld;
  logic          req_op;
  logic [3:0]    req_qid;
  logic          rsp_vld;
  logic [DW-1:0] rsp_data;
  logic          rsp_empty;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_on  = 1'b0;
  bit done    = 1'b0;

  logic [DW-1:0] model_q[$];
  logic [DW-1:0] exp_data[$];
  bit            exp_empty[$];
  string         exp_tag[$];

  always #5 clk = ~clk;

  qbank_top dut_i (
    .clk(clk), .rst_n(rst_n), .trc_vld(trc_vld), .trc_ip(trc_ip),
    .req_vld(req_vld), .req_op(req_op), .req_qid(req_qid),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .rsp_empty(rsp_empty)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and records the expected response.
  task automatic step(input bit tv, input logic [DW-1:0] ip, input bit rv,
                      input bit op, input logic [3:0] qid, input string tag);
    @(negedge clk);
    trc_vld = tv; trc_ip = ip; req_vld = rv; req_op = op; req_qid = qid;
    if (rv) begin
      if (qid == 4'd15 && model_q.size() > 0) begin
        exp_data.push_back(model_q[0]); exp_empty.push_back(1'b0);
      end else begin
        exp_data.push_back('0); exp_empty.push_back(1'b1);
      end
      exp_tag.push_back(tag);
      if (op && qid == 4'd15 && model_q.size() > 0) void'(model_q.pop_front());
    end
    if (tv) begin
      if (model_q.size() == DEPTH) void'(model_q.pop_front());
      model_q.push_back(ip);
    end
  endtask

  task automatic push_only(input logic [DW-1:0] ip);
    step(1'b1, ip, 1'b0, 1'b0, 4'd0, "R7");
  endtask

  task automatic req(input bit op, input logic [3:0] qid, input string tag);
    step(1'b0, '0, 1'b1, op, qid, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 4'd0, "R6");
  endtask

  // Monitor: compares each response against the scoreboard, 2 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on) begin
        if (exp_data.size() > 0) begin
          logic [DW-1:0] ed;
          bit            ee;
          string         tg;
          ed = exp_data.pop_front(); ee = exp_empty.pop_front(); tg = exp_tag.pop_front();
          check(rsp_vld === 1'b1, "R6", "rsp_vld after request", DW'(rsp_vld), 64'd1);
          check(rsp_data === ed, tg, "rsp_data", rsp_data, ed);
          check(rsp_empty === ee, tg, "rsp_empty", DW'(rsp_empty), DW'(ee));
        end else begin
          check(rsp_vld === 1'b0, "R6", "rsp_vld idle", DW'(rsp_vld), 64'd0);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trc_vld = 1'b0; trc_ip = '0;
    req_vld = 1'b0; req_op = 1'b0; req_qid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(rsp_vld === 1'b0, "R10", "rsp_vld after reset", DW'(rsp_vld), 64'd0);
    mon_on = 1'b1;

    // R10 / R5: empty after reset
    req(1'b0, 4'd15, "R10");
    req(1'b1, 4'd15, "R5");
    // R9: peek in the cycle that pushes into an empty queue
    step(1'b1, 64'hA000_0000_0000_00A0, 1'b1, 1'b0, 4'd15, "R9");
    push_only(64'hB000_0000_0000_00B0);
    push_only(64'hC000_0000_0000_00C0);
    // R1 / R2: peeks keep the head
    req(1'b0, 4'd15, "R1");
    req(1'b0, 4'd15, "R2");
    // R4: undefined numbers, both ends and middle, pop and peek
    req(1'b0, 4'd0, "R4");
    req(1'b1, 4'd14, "R4");
    req(1'b1, 4'd7, "R4");
    req(1'b0, 4'd15, "R4");
    // R3: pops in order
    req(1'b1, 4'd15, "R3");
    req(1'b1, 4'd15, "R3");
    // R8: push and pop together, then drain to confirm count
    step(1'b1, 64'hD000_0000_0000_00D0, 1'b1, 1'b1, 4'd15, "R8");
    req(1'b1, 4'd15, "R8");
    req(1'b1, 4'd15, "R8");
    req(1'b0, 4'd15, "R5");
    idle(2);
    // R7: overfill by four
    for (int i = 0; i < 20; i++) push_only(64'h100 + 64'(i));
    req(1'b0, 4'd15, "R7");
    // R8 on a full queue
    step(1'b1, 64'hFEED_0000_0000_0001, 1'b1, 1'b1, 4'd15, "R8");
    for (int i = 0; i < DEPTH; i++) req(1'b1, 4'd15, "R7");
    req(1'b1, 4'd15, "R5");
    idle(3);

    check(exp_data.size() == 0, "R6", "pending responses", DW'(exp_data.size()), 64'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule